// File: doc/BRIEF.md
# High-Side Driver Fault Supervisor

This block sits between the fault comparators of a high-side load driver and its two predrivers. Each clock it looks at five synchronized fault inputs (overcurrent, overvoltage, short to battery, short to ground, open load) together with the two drive-request inputs, CONTROL and ENA. It decides which fault to record in a five-bit report, whether to force the main gate drive off, and whether to turn the clamp device on. It also holds an active-low fault flag.

Faults that can destroy the load or the switches act at once. They latch the predrivers into a safe state and pull the flag low. The first such fault recorded blocks every later report bit. Faults that do no damage are recorded only when the report is still empty. The latched protection and the reported data are released separately. A rising edge on either drive-request input releases the protection. A rising edge on the serial chip-select clears the report bits and the flag.

The overcurrent input passes through a digital persistence filter before it counts as a fault. One configuration bit chooses whether an overvoltage acts as a destructive fault or is only reported.

Top module: `drv_fault_sup`

## Requirements
- R1: After reset the report bits are zero and `fault_n` is 1. `clamp_en` is 0 and `gate_en` follows `ctrl_in & ena_in`. After reset, CONTROL and ENA count as previously low and CSB counts as previously high.
- R2: An overcurrent counts as detected at a clock edge only if `oc_cmp` is high at that edge and was also high at each of the OC_FILT_CYC edges just before it. One low sample restarts the count.
- R3: A detected overcurrent sets report bit 0 and latches `fault_n` low, whatever the drive state. If `ctrl_in` and `ena_in` are both high at that edge, it also latches `gate_en` off and `clamp_en` off.
- R4: Short to battery (report bit 2) and short to ground (report bit 3) are acted on only at edges where `ctrl_in` and `ena_in` are both high. Each latches `gate_en` and `clamp_en` off and latches `fault_n` low.
- R5: A report bit is set only while all five bits are zero, so at most one bit is ever set. When several destructive faults arrive at the same edge, the bit chosen follows the order overcurrent, overvoltage, short to battery, short to ground.
- R6: Open load is sampled at an edge where the drive request (`ctrl_in & ena_in`) was high at the previous edge and is low now. It sets report bit 1 only if no destructive fault is recorded at that edge. It never changes `fault_n`, `gate_en` or `clamp_en`.
- R7: An overvoltage that is not destructive sets report bit 4 only if no other fault is recorded at that edge, and it affects nothing else. An overvoltage is not destructive when `ov_irq_en` is 0, or when the drive request is low. Open load takes precedence over this kind of overvoltage.
- R8: With `ov_irq_en` 1 and the drive request high, an overvoltage is destructive. It latches `gate_en` off, latches `clamp_en` on and latches `fault_n` low. It reports through bit 4 under the order of R5. If an overcurrent or short trips at the same edge, the clamp stays off.
- R9: A rising edge of `ctrl_in` or of `ena_in` releases the latched gate-off and clamp-on states. The report bits and `fault_n` are left unchanged. A trip at the same edge wins over the release.
- R10: A rising edge of `csb_in` clears all report bits and returns `fault_n` to 1, with no effect on the protection latches. A fault at that same edge is neither recorded nor flagged.
- R11: `status_word` holds the report in bits 4..0 (bit 4 overvoltage, 3 short to ground, 2 short to battery, 1 open load, 0 overcurrent, 1 meaning fault), and bits 15..5 read 0. `clamp_en` turns on only through the path of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_in | input | 1 | CONTROL drive request |
| ena_in | input | 1 | ENA drive request |
| csb_in | input | 1 | Serial chip select; rising edge clears report data |
| ov_irq_en | input | 1 | Overvoltage interrupt enable from configuration |
| oc_cmp | input | 1 | Overcurrent comparator (synchronized) |
| ov_cmp | input | 1 | Overvoltage comparator (synchronized) |
| stb_cmp | input | 1 | Short-to-battery comparator (synchronized) |
| stg_cmp | input | 1 | Short-to-ground comparator (synchronized) |
| ol_cmp | input | 1 | Open-load comparator (synchronized) |
| gate_en | output | 1 | Main gate predriver enable |
| clamp_en | output | 1 | Clamp predriver enable |
| fault_n | output | 1 | Active-low latched fault flag |
| status_word | output | 16 | Fault report word for serial readout |

## Verification
The hardest state to reach is the one where several things land on the same clock edge. Examples are two or three destructive faults arriving together, a trip on the very edge that releases protection, and a chip-select rising edge while a fault is still present. Directed sequences bring each of these about. They hold the drive request high, raise the chosen comparators together, and time the CSB or drive edges so they fall on the trip edge. A long pseudo-random phase follows. It keeps CSB edges rare, so that latched states survive long enough to collide with new faults. A behavioural model checks every cycle of it.

// File: rtl/drv_fault_pkg.sv
// Package: shared report-bit positions, priority orders and selection helpers
// for the driver fault supervisor. Bit positions are fixed because the
// serial readout decodes them.
package drv_fault_pkg;

    localparam int unsigned NUM_FB   = 5;
    localparam int unsigned STATUS_W = 16;

    localparam int unsigned FB_OC  = 0;
    localparam int unsigned FB_OL  = 1;
    localparam int unsigned FB_STB = 2;
    localparam int unsigned FB_STG = 3;
    localparam int unsigned FB_OV  = 4;

    typedef logic [NUM_FB-1:0] fbits_t;

    localparam int unsigned NUM_DEST = 4;
    localparam int unsigned NUM_ND   = 2;

    // Order in which simultaneous destructive faults are reported.
    localparam int unsigned DEST_ORDER [NUM_DEST] = '{FB_OC, FB_OV, FB_STB, FB_STG};
    // Order in which simultaneous non-destructive faults are reported.
    localparam int unsigned ND_ORDER   [NUM_ND]   = '{FB_OL, FB_OV};

    // Keep only the highest-priority destructive candidate.
    function automatic fbits_t pick_dest(input fbits_t v);
        fbits_t r;
        r = '0;
        for (int i = NUM_DEST - 1; i >= 0; i--) begin
            if (v[DEST_ORDER[i]]) begin
                r = '0;
                r[DEST_ORDER[i]] = 1'b1;
            end
        end
        return r;
    endfunction

    // Keep only the highest-priority non-destructive candidate.
    function automatic fbits_t pick_nd(input fbits_t v);
        fbits_t r;
        r = '0;
        for (int i = NUM_ND - 1; i >= 0; i--) begin
            if (v[ND_ORDER[i]]) begin
                r = '0;
                r[ND_ORDER[i]] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dfm_oc_filter.sv
// Overcurrent persistence filter.
// Counts consecutive clocks with the comparator high and saturates at
// FILT_CYC. The output is asserted while the comparator is high and the
// count has saturated. Assumes cmp_in is already synchronized.
module dfm_oc_filter #(
    parameter int unsigned FILT_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic det_out
);
    localparam int unsigned CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYC);

    logic [CNT_W-1:0] run_cnt;

    // Purpose: count the run of high samples, restart on any low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!cmp_in) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign det_out = cmp_in && (run_cnt == CNT_MAX);

    // R2
    oc_run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_in |=> (run_cnt == '0));

    // R2
    oc_det_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_out |-> $past(cmp_in));

endmodule

// File: rtl/dfm_edge_track.sv
// Edge tracker for the drive-request and chip-select inputs.
// Keeps the previous sample of each input. After reset, CONTROL and ENA
// count as low and CSB as high, so that no CSB clear fires on the first
// edge. Assumes all inputs are synchronous to clk.
module dfm_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_in,
    input  logic ena_in,
    input  logic csb_in,
    output logic drv_now,
    output logic drv_rise,
    output logic drv_fall,
    output logic csb_rise
);
    logic ctrl_q;
    logic ena_q;
    logic csb_q;

    // Purpose: hold the previous sample of each tracked input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            ena_q  <= 1'b0;
            csb_q  <= 1'b1;
        end else begin
            ctrl_q <= ctrl_in;
            ena_q  <= ena_in;
            csb_q  <= csb_in;
        end
    end

    assign drv_now  = ctrl_in & ena_in;
    assign drv_rise = (ctrl_in & ~ctrl_q) | (ena_in & ~ena_q);
    assign drv_fall = (ctrl_q & ena_q) & ~drv_now;
    assign csb_rise = csb_in & ~csb_q;

endmodule

// File: rtl/dfm_report.sv
// Fault report register and fault flag.
// Records one fault bit while the report is empty: a destructive candidate
// first, by fixed priority, otherwise a non-destructive one. Any destructive
// candidate latches the flag, even when the report is already occupied.
// A clear request wins over a new event at the same edge.
module dfm_report
    import drv_fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  fbits_t dest_cand,
    input  fbits_t nd_cand,
    input  logic   clear_req,
    output fbits_t fault_bits,
    output logic   fault_n
);
    fbits_t rpt_q;
    logic   flag_q;
    fbits_t rpt_pick;

    // Purpose: choose the single bit to record when the report is empty.
    always_comb begin
        if (|dest_cand) begin
            rpt_pick = pick_dest(dest_cand);
        end else begin
            rpt_pick = pick_nd(nd_cand);
        end
    end

    // Purpose: report register with lock-out and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_q <= '0;
        end else if (clear_req) begin
            rpt_q <= '0;
        end else if (rpt_q == '0) begin
            rpt_q <= rpt_pick;
        end
    end

    // Purpose: latched fault flag, set by any destructive candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clear_req) begin
            flag_q <= 1'b0;
        end else if (|dest_cand) begin
            flag_q <= 1'b1;
        end
    end

    assign fault_bits = rpt_q;
    assign fault_n    = ~flag_q;

    // R5
    rpt_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_bits));

    // R5
    rpt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_bits != '0 && !clear_req) |=> $stable(fault_bits));

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (fault_bits == '0 && fault_n));

    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(|dest_cand));

endmodule

// File: rtl/dfm_protect.sv
// Predriver protection latches.
// gate_kill forces the main gate off. clamp_hold forces the clamp on.
// A release request clears both, but a trip at the same edge takes
// precedence. An off-trip (overcurrent or short) wins over a clamp trip.
module dfm_protect (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_off,
    input  logic trip_clamp,
    input  logic release_req,
    output logic gate_kill,
    output logic clamp_hold
);
    // Purpose: latch the protective predriver state until released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_kill  <= 1'b0;
            clamp_hold <= 1'b0;
        end else if (trip_off) begin
            gate_kill  <= 1'b1;
            clamp_hold <= 1'b0;
        end else if (trip_clamp) begin
            gate_kill  <= 1'b1;
            clamp_hold <= 1'b1;
        end else if (release_req) begin
            gate_kill  <= 1'b0;
            clamp_hold <= 1'b0;
        end
    end

    // R11
    clamp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_hold) |-> $past(trip_clamp));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && !trip_off && !trip_clamp) |=> (!gate_kill && !clamp_hold));

    // R8
    clamp_implies_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_hold |-> gate_kill);

endmodule

// File: rtl/drv_fault_sup.sv
// Top level of the high-side driver fault supervisor.
// Classifies the comparator inputs against the drive state into destructive
// and non-destructive candidates. It feeds the report register and the
// protection latches and forms the predriver enables. Assumes every
// comparator input and drive input is synchronized to clk.
module drv_fault_sup
    import drv_fault_pkg::*;
#(
    parameter int unsigned OC_FILT_CYC = 62500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_in,
    input  logic                ena_in,
    input  logic                csb_in,
    input  logic                ov_irq_en,
    input  logic                oc_cmp,
    input  logic                ov_cmp,
    input  logic                stb_cmp,
    input  logic                stg_cmp,
    input  logic                ol_cmp,
    output logic                gate_en,
    output logic                clamp_en,
    output logic                fault_n,
    output logic [STATUS_W-1:0] status_word
);
    logic   drv_now, drv_rise, drv_fall, csb_rise;
    logic   oc_det;
    logic   ov_dest;
    fbits_t dest_cand, nd_cand, fault_bits;
    logic   trip_off;
    logic   gate_kill, clamp_hold;

    dfm_edge_track i_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_in  (ctrl_in),
        .ena_in   (ena_in),
        .csb_in   (csb_in),
        .drv_now  (drv_now),
        .drv_rise (drv_rise),
        .drv_fall (drv_fall),
        .csb_rise (csb_rise)
    );

    dfm_oc_filter #(.FILT_CYC(OC_FILT_CYC)) i_oc_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_in  (oc_cmp),
        .det_out (oc_det)
    );

    assign ov_dest = ov_cmp & ov_irq_en & drv_now;

    // Purpose: sort comparator events into destructive and benign candidates.
    always_comb begin
        dest_cand         = '0;
        dest_cand[FB_OC]  = oc_det;
        dest_cand[FB_OV]  = ov_dest;
        dest_cand[FB_STB] = stb_cmp & drv_now;
        dest_cand[FB_STG] = stg_cmp & drv_now;
        nd_cand           = '0;
        nd_cand[FB_OL]    = ol_cmp & drv_fall;
        nd_cand[FB_OV]    = ov_cmp & ~ov_dest;
    end

    assign trip_off = (oc_det & drv_now) | dest_cand[FB_STB] | dest_cand[FB_STG];

    dfm_report i_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .dest_cand  (dest_cand),
        .nd_cand    (nd_cand),
        .clear_req  (csb_rise),
        .fault_bits (fault_bits),
        .fault_n    (fault_n)
    );

    dfm_protect i_protect (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_off    (trip_off),
        .trip_clamp  (ov_dest),
        .release_req (drv_rise),
        .gate_kill   (gate_kill),
        .clamp_hold  (clamp_hold)
    );

    assign gate_en     = drv_now & ~gate_kill;
    assign clamp_en    = clamp_hold;
    assign status_word = {{(STATUS_W-NUM_FB){1'b0}}, fault_bits};

    // R4
    short_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_now && !oc_det && !ov_dest) |=> !$fell(fault_n));

    // R6
    ol_benign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_cmp && drv_fall && dest_cand == '0 && !csb_rise) |=> ($stable(fault_n) || fault_n));

endmodule

// File: tb/test_drv_fault_sup.sv
// Self-checking bench: a behavioural reference model, updated at each
// clock edge from the applied inputs, is compared with the outputs
// 2 ns after every edge. Directed phases are followed by a random phase.
module test_drv_fault_sup;

    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c = 0, e = 0, s = 1, ovi = 0, oc = 0, ov = 0, sb = 0, sg = 0, ol = 0;
    logic gate_en, clamp_en, fault_n;
    logic [15:0] status_word;

    always #4 clk = ~clk;   // 125 MHz

    drv_fault_sup #(.OC_FILT_CYC(FILT)) i_drv_fault_sup (
        .clk(clk), .rst_n(rst_n), .ctrl_in(c), .ena_in(e), .csb_in(s),
        .ov_irq_en(ovi), .oc_cmp(oc), .ov_cmp(ov), .stb_cmp(sb),
        .stg_cmp(sg), .ol_cmp(ol), .gate_en(gate_en), .clamp_en(clamp_en),
        .fault_n(fault_n), .status_word(status_word)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1";

    // reference model state
    int m_bits = 0;
    bit m_flag = 0, m_kill = 0, m_clamp = 0;
    int m_run = 0;
    bit m_pc = 0, m_pe = 0, m_ps = 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic model_edge();
        bit drive, rise, fall, csr, ocd, dOC, dOV, dSB, dSG, anyd;
        if (!rst_n) begin
            m_bits = 0; m_flag = 0; m_kill = 0; m_clamp = 0; m_run = 0;
            m_pc = 0; m_pe = 0; m_ps = 1;
            return;
        end
        drive = c & e;
        rise  = (c & !m_pc) | (e & !m_pe);
        fall  = m_pc & m_pe & !drive;
        csr   = s & !m_ps;
        ocd   = oc && (m_run == FILT);
        m_run = oc ? ((m_run < FILT) ? m_run + 1 : FILT) : 0;
        dOC = ocd; dOV = ov & ovi & drive; dSB = sb & drive; dSG = sg & drive;
        anyd = dOC | dOV | dSB | dSG;
        if (csr) begin
            m_bits = 0; m_flag = 0;
        end else begin
            if (m_bits == 0) begin
                if (dOC) m_bits = 1;
                else if (dOV) m_bits = 16;
                else if (dSB) m_bits = 4;
                else if (dSG) m_bits = 8;
                else if (fall & ol) m_bits = 2;
                else if (ov) m_bits = 16;
            end
            if (anyd) m_flag = 1;
        end
        if ((dOC & drive) | dSB | dSG) begin m_kill = 1; m_clamp = 0; end
        else if (dOV) begin m_kill = 1; m_clamp = 1; end
        else if (rise) begin m_kill = 0; m_clamp = 0; end
        m_pc = c; m_pe = e; m_ps = s;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        if (rst_n) begin
            chk({phase, " gate_en"}, gate_en, (c & e) & !m_kill);
            chk({phase, " clamp_en"}, clamp_en, m_clamp);
            chk({phase, " fault_n"}, fault_n, !m_flag);
            chk({phase, " status_word"}, status_word, m_bits);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic csb_pulse();
        s = 0; tick(); s = 1; tick();
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        ticks(3);
        rst_n = 1;
        tick();
        chk("R1 status", status_word, 0);
        chk("R1 fault_n", fault_n, 1);
        chk("R1 clamp", clamp_en, 0);
        // R11: gate follows drive, upper word bits zero
        phase = "R11";
        c = 1; e = 1; tick();
        chk("R11 gate on", gate_en, 1);
        e = 0; tick();
        chk("R11 gate off", gate_en, 0);
        chk("R11 upper bits", status_word[15:5], 0);
        // R2: short overcurrent pulses are filtered
        phase = "R2";
        oc = 1; ticks(FILT); oc = 0; tick();
        chk("R2 filtered", status_word, 0);
        oc = 1; ticks(FILT - 1); oc = 0; tick(); oc = 1; ticks(FILT);
        chk("R2 restarted", status_word, 0);
        // R3: overcurrent with drive low reports, flag low, gate untouched
        phase = "R3";
        tick();
        chk("R3 bit0", status_word, 1);
        chk("R3 flag", fault_n, 0);
        oc = 0; tick();
        phase = "R10";
        csb_pulse();
        chk("R10 cleared", status_word, 0);
        chk("R10 flag", fault_n, 1);
        // R3: overcurrent with drive high latches gate off
        phase = "R3";
        c = 1; e = 1; tick();
        oc = 1; ticks(FILT + 1); oc = 0; tick();
        chk("R3 gate latched", gate_en, 0);
        chk("R3 clamp off", clamp_en, 0);
        // R9: release on rising CONTROL keeps data
        phase = "R9";
        c = 0; tick(); c = 1; tick();
        chk("R9 gate back", gate_en, 1);
        chk("R9 bits kept", status_word, 1);
        chk("R9 flag kept", fault_n, 0);
        csb_pulse();
        // R4: shorts need drive
        phase = "R4";
        e = 0; sb = 1; sg = 1; ticks(2);
        chk("R4 ignored", status_word, 0);
        chk("R4 flag ignored", fault_n, 1);
        sg = 0; e = 1; tick();
        chk("R4 stb bit", status_word, 4);
        chk("R4 gate off", gate_en, 0);
        sb = 0; sg = 1; tick();
        // R5: locked to first fault
        phase = "R5";
        chk("R5 locked", status_word, 4);
        // R10: clear while short persists, clear wins that edge
        phase = "R10";
        s = 0; tick(); s = 1; tick();
        chk("R10 clear wins", status_word, 0);
        chk("R10 protection kept", gate_en, 0);
        tick();
        chk("R10 re-record", status_word, 8);
        sg = 0; e = 0; tick(); e = 1; tick(); csb_pulse();
        // R5 and R8: simultaneous destructive faults
        phase = "R8";
        ovi = 1; ov = 1; sb = 1; sg = 1; tick();
        chk("R5 ov first", status_word, 16);
        chk("R8 clamp off due short", clamp_en, 0);
        ov = 0; sb = 0; sg = 0; c = 0; tick(); c = 1; tick(); csb_pulse();
        ov = 1; tick(); ov = 0;
        chk("R8 clamp on", clamp_en, 1);
        chk("R8 gate off", gate_en, 0);
        chk("R8 flag", fault_n, 0);
        csb_pulse();
        chk("R10 clamp survives clear", clamp_en, 1);
        e = 0; tick(); e = 1; tick();
        chk("R9 clamp released", clamp_en, 0);
        sb = 1; sg = 1; tick(); sb = 0; sg = 0;
        phase = "R5";
        chk("R5 stb over stg", status_word, 4);
        c = 0; tick(); c = 1; tick(); csb_pulse();
        // R6: open load at drive fall
        phase = "R6";
        ol = 1; c = 0; tick(); ol = 0;
        chk("R6 bit1", status_word, 2);
        chk("R6 flag", fault_n, 1);
        csb_pulse();
        // R7: benign overvoltage
        phase = "R7";
        ovi = 0; c = 1; tick(); ov = 1; tick(); ov = 0;
        chk("R7 bit4", status_word, 16);
        chk("R7 gate", gate_en, 1);
        chk("R7 flag", fault_n, 1);
        tick();
        // random phase against the model
        phase = "R5 random";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            c = r[0] | r[1]; e = r[2] | r[3] | r[4];
            s = (r[9:5] == 0) ? ~s : s;
            ovi = r[10]; oc = r[11] | r[12] | r[13]; ov = (r[16:14] == 0);
            sb = (r[20:17] == 0); sg = (r[24:21] == 0); ol = r[25];
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule